// File: doc/BRIEF.md
# Dual-Current Fault Detect and Select

This block sits behind the current-sensing path of a single-phase energy meter that senses both the phase conductor (channel A) and the neutral return (channel B). On each sample strobe it takes two unsigned, already averaged magnitude words, one per conductor, and decides which conductor feeds the billing path. It raises a fault level when the two disagree beyond a tolerance band. Billing therefore always follows the larger current once a sustained imbalance has been seen.

Ratios are judged with shift-and-add limits derived from the magnitude of the billing (active) channel. The fault flag and the channel swap use different limits. Both take effect only after a condition has held over a number of consecutive strobes. A light-load gate, set against a full-scale input, suppresses both decisions when the signal is too small to trust. Both outputs are registered and change only on strobed clock edges.

Top module: `dual_feed_guard`

## Requirements
- R1: After synchronous reset, `sel_b` is 0 (channel A bills) and `fault` is 0.
- R2: `sel_b` and `fault` change only on a rising clock edge where `smp_stb` is 1. Input changes without a strobe have no effect on them.
- R3: Let act be the active magnitude (`mag_b` when `sel_b`=1, else `mag_a`) and ina the other one. A low mismatch exists when ina < act − (act>>3), using integer shifts. ina equal to that limit is not a mismatch.
- R4: A high mismatch exists when ina > act + (act>>3) + (act>>6), computed without overflow. ina equal to that limit is not a mismatch.
- R5: With `fault`=0, `fault` becomes 1 on the FAULT_TICKS-th consecutive strobe that shows a low or high mismatch and no light load. Any strobe without one restarts the count.
- R6: `sel_b` toggles on the SWAP_TICKS-th consecutive strobe that shows a high mismatch and no light load. Any strobe without one restarts the count.
- R7: After a swap, the channel that was swapped out becomes active again only through a new high mismatch against the current active channel. A return into the band alone never swaps back.
- R8: With `fault`=1, `fault` clears on the first strobe with neither a low nor a high mismatch, whichever channel is active.
- R9: Light load is act < (`full_scale`>>8) + (`full_scale`>>9). On a light-load strobe, `fault` goes to 0, no swap occurs, and both persistence counts restart.
- R10: If B exceeds the high limit of A from reset onward, B becomes active on the SWAP_TICKS-th strobe, after `fault` has risen on the FAULT_TICKS-th.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe, one cycle per new magnitude pair |
| mag_a | input | W | Averaged magnitude of the phase conductor |
| mag_b | input | W | Averaged magnitude of the neutral conductor |
| full_scale | input | W | Full-scale magnitude used for the light-load gate |
| sel_b | output | 1 | 1 when channel B is the billing input |
| fault | output | 1 | Current mismatch flag |

## Verification
Light-load gating and swap completion can land on the same strobe. The bench drives a high mismatch for one strobe fewer than SWAP_TICKS, then drops the active magnitude below the light-load limit on the very strobe that would finish the swap. The expected result is that light load wins: the selection stays put and the flag clears that strobe. The behavioural reference in the bench judges this each clock, and a named check confirms it at the ports.

// File: rtl/dfg_pkg.sv
package dfg_pkg;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;

    typedef struct packed {
        logic light;
        logic low;
        logic high;
    } verdict_t;

endpackage

// File: rtl/dfg_classify.sv
module dfg_classify
    import dfg_pkg::*;
#(
    parameter int W = 16
) (
    input  chan_e          sel,
    input  logic [W-1:0]   mag_a,
    input  logic [W-1:0]   mag_b,
    input  logic [W-1:0]   full_scale,
    output verdict_t       verdict
);

    logic [W-1:0] act;
    logic [W-1:0] ina;
    logic [W-1:0] lo_lim;
    logic [W:0]   hi_lim;
    logic [W-1:0] light_lim;

    always_comb begin
        act       = (sel == CH_B) ? mag_b : mag_a;
        ina       = (sel == CH_B) ? mag_a : mag_b;
        lo_lim    = act - (act >> 3);
        hi_lim    = (W+1)'(act) + (W+1)'(act >> 3) + (W+1)'(act >> 6);
        light_lim = (full_scale >> 8) + (full_scale >> 9);
        verdict.light = (act < light_lim);
        verdict.low   = (ina < lo_lim);
        verdict.high  = ((W+1)'(ina) > hi_lim);
    end

endmodule

// File: rtl/dfg_persist.sv
module dfg_persist #(
    parameter int TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic qual,
    output logic hit
);

    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    assign hit = stb && qual && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (stb) begin
            if (!qual || hit)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dual_feed_guard.sv
module dual_feed_guard
    import dfg_pkg::*;
#(
    parameter int W           = 16,
    parameter int FAULT_TICKS = 10,
    parameter int SWAP_TICKS  = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         smp_stb,
    input  logic [W-1:0] mag_a,
    input  logic [W-1:0] mag_b,
    input  logic [W-1:0] full_scale,
    output logic         sel_b,
    output logic         fault
);

    chan_e    sel_q;
    logic     fault_q;
    verdict_t vd;
    logic     mismatch;
    logic     fault_qual;
    logic     swap_qual;
    logic     fault_hit;
    logic     swap_hit;

    dfg_classify #(.W(W)) u_cls (
        .sel        (sel_q),
        .mag_a      (mag_a),
        .mag_b      (mag_b),
        .full_scale (full_scale),
        .verdict    (vd)
    );

    assign mismatch   = vd.low || vd.high;
    assign fault_qual = mismatch && !vd.light && !fault_q;
    assign swap_qual  = vd.high && !vd.light;

    dfg_persist #(.TICKS(FAULT_TICKS)) u_fault_cnt (
        .clk  (clk),
        .rst  (rst),
        .stb  (smp_stb),
        .qual (fault_qual),
        .hit  (fault_hit)
    );

    dfg_persist #(.TICKS(SWAP_TICKS)) u_swap_cnt (
        .clk  (clk),
        .rst  (rst),
        .stb  (smp_stb),
        .qual (swap_qual),
        .hit  (swap_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= CH_A;
            fault_q <= 1'b0;
        end else if (smp_stb) begin
            if (swap_hit)
                sel_q <= (sel_q == CH_A) ? CH_B : CH_A;
            if (fault_q)
                fault_q <= mismatch && !vd.light;
            else if (fault_hit)
                fault_q <= 1'b1;
        end
    end

    assign sel_b = (sel_q == CH_B);
    assign fault = fault_q;

endmodule

// File: rtl/dfg_checker.sv
module dfg_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         smp_stb,
    input logic [W-1:0] mag_a,
    input logic [W-1:0] mag_b,
    input logic [W-1:0] full_scale,
    input logic         sel_b,
    input logic         fault
);

    logic [W-1:0] c_act;
    logic [W-1:0] c_ina;
    logic         c_low;
    logic         c_high;
    logic         c_light;

    always_comb begin
        c_act   = sel_b ? mag_b : mag_a;
        c_ina   = sel_b ? mag_a : mag_b;
        c_low   = ({1'b0, c_ina} << 3) < ({1'b0, c_act} << 3) - ({1'b0, c_act} & ~(W+1)'(7));
        c_high  = (W+1)'(c_ina) > ((W+1)'(c_act) + (W+1)'(c_act >> 3) + (W+1)'(c_act >> 6));
        c_light = c_act < ((full_scale >> 8) + (full_scale >> 9));
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!sel_b && !fault));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> ($stable(sel_b) && $stable(fault)));

    p_swap_cause_r6: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !c_high) |=> $stable(sel_b));

    p_light_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && c_light) |=> (!fault && $stable(sel_b)));

    p_band_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !c_high && !c_low) |=> !fault);

    p_rise_cause_r5: assert property (@(posedge clk) disable iff (rst)
        (!fault && !(smp_stb && (c_low || c_high))) |=> !fault);

endmodule

bind dual_feed_guard dfg_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_stb    (smp_stb),
    .mag_a      (mag_a),
    .mag_b      (mag_b),
    .full_scale (full_scale),
    .sel_b      (sel_b),
    .fault      (fault)
);

// File: tb/dual_feed_guard_tb.sv
module dual_feed_guard_tb;

    localparam int W  = 16;
    localparam int FT = 10;
    localparam int ST = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         smp_stb = 1'b0;
    logic [W-1:0] mag_a = '0;
    logic [W-1:0] mag_b = '0;
    logic [W-1:0] full_scale = 16'd40000;
    logic         sel_b;
    logic         fault;

    int    n_chk  = 0;
    int    n_fail = 0;
    string phase  = "R1";
    bit    done   = 0;

    // behavioural reference state
    int m_sel = 0, m_fault = 0, fcnt = 0, scnt = 0;

    always #4 clk = ~clk;

    dual_feed_guard #(.W(W), .FAULT_TICKS(FT), .SWAP_TICKS(ST)) u_dut (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .mag_a(mag_a), .mag_b(mag_b),
        .full_scale(full_scale), .sel_b(sel_b), .fault(fault)
    );

    always @(posedge clk) begin
        int act, ina, nf;
        bit light, low, high, mis;
        if (rst) begin
            m_sel = 0; m_fault = 0; fcnt = 0; scnt = 0;
        end else if (smp_stb) begin
            act   = m_sel ? int'(mag_b) : int'(mag_a);
            ina   = m_sel ? int'(mag_a) : int'(mag_b);
            light = act < (int'(full_scale) / 256 + int'(full_scale) / 512);
            low   = ina < act - act / 8;
            high  = ina > act + act / 8 + act / 64;
            mis   = low || high;
            nf    = m_fault;
            if (m_fault != 0) begin
                nf = (mis && !light) ? 1 : 0;
                fcnt = 0;
            end else if (mis && !light) begin
                if (fcnt == FT - 1) begin nf = 1; fcnt = 0; end
                else fcnt++;
            end else fcnt = 0;
            if (high && !light) begin
                if (scnt == ST - 1) begin m_sel = 1 - m_sel; scnt = 0; end
                else scnt++;
            end else scnt = 0;
            m_fault = nf;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            n_chk++;
            if (sel_b !== m_sel[0] || fault !== m_fault[0]) begin
                n_fail++;
                $display("FAIL %s per-clock: sel_b=%0b fault=%0b expected sel_b=%0b fault=%0b",
                         phase, sel_b, fault, m_sel[0], m_fault[0]);
            end
        end
    end

    task automatic expect_out(input string tag, input logic es, input logic ef);
        n_chk++;
        if (sel_b !== es || fault !== ef) begin
            n_fail++;
            $display("FAIL %s: sel_b=%0b fault=%0b expected sel_b=%0b fault=%0b",
                     tag, sel_b, fault, es, ef);
        end
    endtask

    task automatic strobes(input int n);
        for (int k = 0; k < n; k++) begin
            repeat (1 + (k % 3)) @(negedge clk);
            smp_stb = 1'b1;
            @(negedge clk);
            smp_stb = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_out("R1", 1'b0, 1'b0);

        // B high from reset: fault at FT, swap at ST
        phase = "R10";
        mag_a = 16'd1000; mag_b = 16'd1200;
        strobes(FT - 1); expect_out("R5", 1'b0, 1'b0);
        strobes(1);      expect_out("R5", 1'b0, 1'b1);
        strobes(ST - FT - 1); expect_out("R10", 1'b0, 1'b1);
        strobes(1);      expect_out("R10", 1'b1, 1'b1);
        strobes(1);      expect_out("R3", 1'b1, 1'b1);

        // back into band: fault clears, no swap back
        phase = "R8";
        mag_a = 16'd1100;
        strobes(1);      expect_out("R8", 1'b1, 1'b0);
        phase = "R7";
        strobes(20);     expect_out("R7", 1'b1, 1'b0);
        mag_a = 16'd1300;
        strobes(15);     expect_out("R7", 1'b1, 1'b0);
        mag_a = 16'd1400;
        strobes(FT);     expect_out("R5", 1'b1, 1'b1);
        strobes(ST - FT); expect_out("R6", 1'b0, 1'b1);

        // low mismatch with A active (act 1400, low limit 1225)
        phase = "R3";
        mag_b = 16'd1300;
        strobes(1);      expect_out("R8", 1'b0, 1'b0);
        mag_b = 16'd1225;
        strobes(15);     expect_out("R3", 1'b0, 1'b0);
        mag_b = 16'd1224;
        strobes(FT - 1); expect_out("R3", 1'b0, 1'b0);
        strobes(1);      expect_out("R3", 1'b0, 1'b1);

        // restart of the fault count on a gap
        phase = "R5";
        mag_b = 16'd1300;
        strobes(1);      expect_out("R8", 1'b0, 1'b0);
        mag_b = 16'd1224;
        strobes(7);
        mag_b = 16'd1300;
        strobes(1);
        mag_b = 16'd1224;
        strobes(FT - 1); expect_out("R5", 1'b0, 1'b0);
        strobes(1);      expect_out("R5", 1'b0, 1'b1);

        // no strobe: outputs frozen
        phase = "R2";
        mag_b = 16'd1300;
        repeat (40) @(negedge clk);
        expect_out("R2", 1'b0, 1'b1);
        strobes(1);      expect_out("R2", 1'b0, 1'b0);

        // high limit boundary (1400 -> 1596)
        phase = "R4";
        mag_b = 16'd1596;
        strobes(15);     expect_out("R4", 1'b0, 1'b0);
        mag_b = 16'd1597;
        strobes(ST - 1); expect_out("R4", 1'b0, 1'b1);

        // light load on the strobe that would finish the swap
        phase = "R9";
        mag_a = 16'd200;
        strobes(1);      expect_out("R9", 1'b0, 1'b0);
        strobes(20);     expect_out("R9", 1'b0, 1'b0);

        // swap count restarts on a gap
        phase = "R6";
        mag_a = 16'd1000; mag_b = 16'd1200;
        strobes(ST - 1); expect_out("R6", 1'b0, 1'b1);
        mag_b = 16'd1100;
        strobes(1);      expect_out("R6", 1'b0, 1'b0);
        mag_b = 16'd1200;
        strobes(ST - 1); expect_out("R6", 1'b0, 1'b1);
        strobes(1);      expect_out("R6", 1'b1, 1'b1);

        done = 1;
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule